// File: doc/BRIEF.md
# Masked SIMD Lane Rotate Unit

This unit rotates every element of a 512-bit vector to the right. Elements are 32 or 64 bits wide. Only the low 128, 256 or 512 bits of the vector take part in an operation. The rotate amount comes from one of two places. In immediate mode, a single 8-bit count applies to every lane. In variable mode, each lane takes its count from the same lane of a second vector. A broadcast option replicates element zero of an operand across all lanes. In immediate mode that operand is the data. In variable mode it is the count vector.

After the rotation, a per-lane writemask can apply. Under merge policy, a lane whose mask bit is clear keeps the previous destination value, which arrives on an input of its own. Under zero policy, such a lane is cleared. Destination bits above the active vector length are always zero.

An operation is offered with a one-cycle valid strobe. The result is registered and appears on the next cycle, together with a one-cycle valid strobe.

Top module: `simd_rotr_unit`

## Requirements
- R1: A synchronous active-high reset clears `out_valid` and `out_data` to zero.
- R2: `out_valid` is high for exactly the one cycle after each cycle with `in_valid` high. `out_data` keeps its value on cycles without `in_valid`.
- R3: Each written lane equals its source rotated right by n, that is (src >> n) | (src << (W - n)). A count of zero returns the source unchanged.
- R4: The effective count of a lane is its count modulo the element width. This is the low 5 bits for `esize`=0 (32-bit elements) and the low 6 bits for `esize`=1 (64-bit elements).
- R5: `vlen` code 0 selects 128 bits, code 1 selects 256 bits, and codes 2 and 3 select 512 bits. This gives 4, 8 or 16 lanes of 32 bits, or 2, 4 or 8 lanes of 64 bits.
- R6: With `var_mode`=0, every lane uses `imm`. With `var_mode`=1, lane j uses the low bits of element j of `src_cnt`.
- R7: With `bcast`=1 and `var_mode`=0, every lane rotates element 0 of `src_a`. With `bcast`=1 and `var_mode`=1, every lane rotates its own element using the count in element 0 of `src_cnt`.
- R8: With `mask_en`=1 and `zero_mode`=0, an active lane j whose bit `mask[j]` is 0 outputs the matching lane of `dest_old`.
- R9: With `mask_en`=1 and `zero_mode`=1, an active lane j whose bit `mask[j]` is 0 outputs zero.
- R10: With `mask_en`=0, every active lane is written with its rotated value, whatever the value of `mask`.
- R11: Output bits at and above the active vector length are zero in every mode.
- R12: Mask bits at an index equal to or greater than the active lane count have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| esize | input | 1 | Element size: 0 selects 32 bits, 1 selects 64 bits |
| vlen | input | 2 | Vector length: 0 is 128, 1 is 256, 2 and 3 are 512 |
| var_mode | input | 1 | 0 selects the immediate count, 1 selects per-lane counts |
| bcast | input | 1 | Replicate element zero of the data (immediate mode) or of the counts (variable mode) |
| mask_en | input | 1 | Enable the writemask |
| zero_mode | input | 1 | Masked-off lanes: 0 merges, 1 zeroes |
| mask | input | 16 | Per-lane write mask, bit j for lane j |
| imm | input | 8 | Shared rotate count |
| src_a | input | 512 | Data vector |
| src_cnt | input | 512 | Per-lane count vector |
| dest_old | input | 512 | Previous destination, used by merge masking |
| out_valid | output | 1 | Result strobe |
| out_data | output | 512 | Registered result |

## Verification
Random data, counts and masks are applied under every combination of element size, vector length code, count mode, broadcast, mask enable and policy. Each combination is compared against a bench model that rotates bit by bit.

Directed cases cover the remaining corner behaviours:
- A count of zero shows that identity rotation is kept.
- Counts of 37 and 70 tell modulo wrapping apart from saturation.
- An all-zero mask under each policy tells merging from zeroing.
- A zero mask with masking disabled shows that the mask is ignored when masking is off.
- Set mask bits beyond the active lanes show that only in-range bits act.
- Variable-mode broadcast, compared with immediate-mode broadcast, shows which operand is replicated.

// File: rtl/rotr_pkg.sv
package rotr_pkg;
  localparam int SLOT_W = 32;
  localparam int WIDE_W = 64;
  localparam int IMM_W  = 8;

  typedef enum logic {ESZ_32 = 1'b0, ESZ_64 = 1'b1} esize_e;
  typedef enum logic [1:0] {VL_128 = 2'd0, VL_256 = 2'd1, VL_512 = 2'd2, VL_RSV = 2'd3} vlen_e;

  function automatic logic [SLOT_W-1:0] rotr32(input logic [SLOT_W-1:0] x, input logic [4:0] n);
    logic [5:0] back;
    back = 6'd32 - {1'b0, n};
    return (x >> n) | (x << back);
  endfunction

  function automatic logic [WIDE_W-1:0] rotr64(input logic [WIDE_W-1:0] x, input logic [5:0] n);
    logic [6:0] back;
    back = 7'd64 - {1'b0, n};
    return (x >> n) | (x << back);
  endfunction

  // Number of active 32-bit slots for a vector length code
  function automatic int unsigned active_slots(input vlen_e v);
    case (v)
      VL_128:  return 4;
      VL_256:  return 8;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/rotr_lane_ctrl.sv
module rotr_lane_ctrl
  import rotr_pkg::*;
#(
  parameter int NSLOT = 16
) (
  input  logic             esize,
  input  logic [1:0]       vlen,
  input  logic             mask_en,
  input  logic [NSLOT-1:0] mask,
  output logic [NSLOT-1:0] slot_active,
  output logic [NSLOT-1:0] slot_write
);
  int unsigned n_act;
  always_comb n_act = active_slots(vlen_e'(vlen));

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic mbit;
    assign mbit           = (esize_e'(esize) == ESZ_64) ? mask[s/2] : mask[s];
    assign slot_active[s] = (s < n_act);
    assign slot_write[s]  = slot_active[s] && (!mask_en || mbit);
  end
endmodule

// File: rtl/rotr_lane_array.sv
module rotr_lane_array
  import rotr_pkg::*;
#(
  parameter int VEC_W = 512
) (
  input  logic             esize,
  input  logic             var_mode,
  input  logic             bcast,
  input  logic [IMM_W-1:0] imm,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_cnt,
  output logic [VEC_W-1:0] rot_vec
);
  localparam int NSLOT = VEC_W / SLOT_W;
  localparam int NWIDE = VEC_W / WIDE_W;

  logic [VEC_W-1:0] rot32, rot64;

  for (genvar s = 0; s < NSLOT; s++) begin : g_n32
    logic [SLOT_W-1:0] d, c;
    logic [4:0]        n;
    assign d = (bcast && !var_mode) ? src_a[SLOT_W-1:0] : src_a[s*SLOT_W +: SLOT_W];
    assign c = bcast ? src_cnt[SLOT_W-1:0] : src_cnt[s*SLOT_W +: SLOT_W];
    assign n = var_mode ? c[4:0] : imm[4:0];
    assign rot32[s*SLOT_W +: SLOT_W] = rotr32(d, n);
  end

  for (genvar k = 0; k < NWIDE; k++) begin : g_n64
    logic [WIDE_W-1:0] d, c;
    logic [5:0]        n;
    assign d = (bcast && !var_mode) ? src_a[WIDE_W-1:0] : src_a[k*WIDE_W +: WIDE_W];
    assign c = bcast ? src_cnt[WIDE_W-1:0] : src_cnt[k*WIDE_W +: WIDE_W];
    assign n = var_mode ? c[5:0] : imm[5:0];
    assign rot64[k*WIDE_W +: WIDE_W] = rotr64(d, n);
  end

  assign rot_vec = (esize_e'(esize) == ESZ_64) ? rot64 : rot32;
endmodule

// File: rtl/simd_rotr_unit.sv
module simd_rotr_unit
  import rotr_pkg::*;
#(
  parameter int VEC_W = 512,
  parameter int MSK_W = VEC_W / SLOT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             esize,
  input  logic [1:0]       vlen,
  input  logic             var_mode,
  input  logic             bcast,
  input  logic             mask_en,
  input  logic             zero_mode,
  input  logic [MSK_W-1:0] mask,
  input  logic [IMM_W-1:0] imm,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_cnt,
  input  logic [VEC_W-1:0] dest_old,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_data
);
  localparam int NSLOT = VEC_W / SLOT_W;

  logic [NSLOT-1:0] slot_active, slot_write;
  logic [VEC_W-1:0] rot_vec, next_data;

  rotr_lane_ctrl #(.NSLOT(NSLOT)) ctrl_i (
    .esize(esize), .vlen(vlen), .mask_en(mask_en), .mask(mask),
    .slot_active(slot_active), .slot_write(slot_write)
  );

  rotr_lane_array #(.VEC_W(VEC_W)) lanes_i (
    .esize(esize), .var_mode(var_mode), .bcast(bcast), .imm(imm),
    .src_a(src_a), .src_cnt(src_cnt), .rot_vec(rot_vec)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_merge
    always_comb begin
      if (!slot_active[s])    next_data[s*SLOT_W +: SLOT_W] = '0;
      else if (slot_write[s]) next_data[s*SLOT_W +: SLOT_W] = rot_vec[s*SLOT_W +: SLOT_W];
      else if (zero_mode)     next_data[s*SLOT_W +: SLOT_W] = '0;
      else                    next_data[s*SLOT_W +: SLOT_W] = dest_old[s*SLOT_W +: SLOT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= next_data;
    end
  end
endmodule

// File: rtl/simd_rotr_unit_chk.sv
module simd_rotr_unit_chk #(
  parameter int VEC_W = 512,
  parameter int MSK_W = 16,
  parameter int NSLOT = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [1:0]       vlen,
  input logic             var_mode,
  input logic             bcast,
  input logic             mask_en,
  input logic             zero_mode,
  input logic [MSK_W-1:0] mask,
  input logic [7:0]       imm,
  input logic [VEC_W-1:0] src_a,
  input logic [VEC_W-1:0] dest_old,
  input logic             out_valid,
  input logic [VEC_W-1:0] out_data,
  input logic [NSLOT-1:0] slot_active,
  input logic [NSLOT-1:0] slot_write
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!out_valid && out_data == '0));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);

  // R2
  hold_data_chk: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(out_data));

  // R3
  zero_count_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !var_mode && imm == 8'd0 && !bcast && !mask_en && vlen[1]) |=> (out_data == $past(src_a)));

  // R8
  merge_all_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_en && !zero_mode && mask == '0 && vlen[1]) |=> (out_data == $past(dest_old)));

  // R9
  zero_all_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_en && zero_mode && mask == '0) |=> (out_data == '0));

  // R11
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && vlen == 2'd0) |=> (out_data[VEC_W-1:128] == '0));

  // R10
  write_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    ((slot_write & ~slot_active) == '0) && (!mask_en -> slot_write == slot_active));
endmodule

bind simd_rotr_unit simd_rotr_unit_chk #(.VEC_W(VEC_W), .MSK_W(MSK_W), .NSLOT(NSLOT)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .vlen(vlen), .var_mode(var_mode),
  .bcast(bcast), .mask_en(mask_en), .zero_mode(zero_mode), .mask(mask), .imm(imm),
  .src_a(src_a), .dest_old(dest_old), .out_valid(out_valid), .out_data(out_data),
  .slot_active(slot_active), .slot_write(slot_write)
);

// File: tb/simd_rotr_unit_tb.sv
`timescale 1ns/1ps
module simd_rotr_unit_tb_top;
  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic esize = 1'b0, var_mode = 1'b0, bcast = 1'b0, mask_en = 1'b0, zero_mode = 1'b0;
  logic [1:0] vlen = 2'd2;
  logic [15:0] mask = '0;
  logic [7:0] imm = '0;
  logic [511:0] src_a = '0, src_cnt = '0, dest_old = '0;
  logic out_valid;
  logic [511:0] out_data;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  simd_rotr_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .esize(esize), .vlen(vlen),
    .var_mode(var_mode), .bcast(bcast), .mask_en(mask_en), .zero_mode(zero_mode),
    .mask(mask), .imm(imm), .src_a(src_a), .src_cnt(src_cnt), .dest_old(dest_old),
    .out_valid(out_valid), .out_data(out_data)
  );

  // Bench model: bit b of a lane takes bit (b + n) mod W of its source.
  function automatic logic [511:0] model();
    logic [511:0] r = '0;
    int w = esize ? 64 : 32;
    int vbits = (vlen == 2'd0) ? 128 : (vlen == 2'd1) ? 256 : 512;
    for (int l = 0; l < vbits / w; l++) begin
      int dbase = (bcast && !var_mode) ? 0 : l * w;
      int cbase = bcast ? 0 : l * w;
      int n = 0;
      if (var_mode) for (int b = 0; b < 8; b++) n += src_cnt[cbase + b] << b;
      else n = imm;
      n = n % w;
      for (int b = 0; b < w; b++) begin
        if (mask_en && !mask[l]) r[l*w + b] = zero_mode ? 1'b0 : dest_old[l*w + b];
        else r[l*w + b] = src_a[dbase + (b + n) % w];
      end
    end
    return r;
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fire(input string req);
    logic [511:0] exp = model();
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {511'd0, out_valid}, 512'd1);
    check(req, out_data, exp);
  endtask

  task automatic cfg(input logic es, input logic [1:0] vl, input logic vm, input logic bc,
                     input logic me, input logic zm);
    esize = es; vlen = vl; var_mode = vm; bcast = bc; mask_en = me; zero_mode = zm;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [511:0] held;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", {511'd0, out_valid}, 512'd0);
    check("R1", out_data, 512'd0);

    src_a = rnd512(); src_cnt = rnd512(); dest_old = rnd512();
    // R3 zero count returns source
    cfg(0, 2'd2, 0, 0, 0, 0); imm = 8'd0; fire("R3");
    check("R3 identity", out_data, src_a);
    // R4 wrap modulo width
    imm = 8'd37; fire("R4 32-bit count 37");
    cfg(1, 2'd2, 0, 0, 0, 0); imm = 8'd70; fire("R4 64-bit count 70");
    // R5 lane count per length code, R11 upper bits zero
    cfg(0, 2'd0, 0, 0, 0, 0); imm = 8'd9; fire("R5 R11 128-bit");
    check("R11", {384'd0, out_data[511:128]}, 512'd0);
    cfg(1, 2'd1, 0, 0, 0, 0); fire("R5 R11 256-bit");
    cfg(0, 2'd3, 0, 0, 0, 0); fire("R5 code 3 as 512");
    // R6 variable counts
    cfg(0, 2'd2, 1, 0, 0, 0); fire("R6 var 32");
    cfg(1, 2'd2, 1, 0, 0, 0); fire("R6 var 64");
    // R7 broadcast both modes
    cfg(0, 2'd2, 0, 1, 0, 0); fire("R7 bcast data");
    cfg(1, 2'd2, 1, 1, 0, 0); fire("R7 bcast count");
    // R8 merge, R9 zero
    mask = 16'h0000;
    cfg(0, 2'd2, 0, 0, 1, 0); fire("R8 merge");
    check("R8 all kept", out_data, dest_old);
    cfg(1, 2'd2, 0, 0, 1, 1); fire("R9 zero");
    check("R9 all zero", out_data, 512'd0);
    // R10 mask ignored when disabled
    cfg(0, 2'd2, 0, 0, 0, 1); fire("R10 mask off");
    // R12 out-of-range mask bits
    mask = 16'hFFF0; cfg(0, 2'd0, 0, 0, 1, 0); fire("R12 32-bit");
    check("R12 kept", {384'd0, out_data[127:0]}, {384'd0, dest_old[127:0]});
    mask = 16'hFFFC; cfg(1, 2'd0, 0, 0, 1, 0); fire("R12 64-bit");
    // R2 hold and single pulse
    held = out_data;
    src_a = rnd512(); imm = 8'd3;
    @(negedge clk);
    check("R2 pulse", {511'd0, out_valid}, 512'd0);
    check("R2 hold", out_data, held);

    // Random mix: R3 R4 R5 R6 R7 R8 R9 R10 R11
    for (int i = 0; i < 400; i++) begin
      src_a = rnd512(); src_cnt = rnd512(); dest_old = rnd512();
      mask = 16'($urandom); imm = 8'($urandom);
      cfg(1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      fire("R3 random");
      if (($urandom & 3) == 0) @(negedge clk);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule